// File: doc/BRIEF.md
# Sleep and Wake Clock Controller

This block governs the clock enables of a small microcontroller while it sleeps. When the CPU issues an idle request, the controller leaves its running state and enters sleep. Two configuration inputs set its sleep behaviour. A clock-stop bit decides whether the main clock and the timer clock are gated off. A wake-mode bit decides whether interrupts end sleep through a clockless capture path or through plain sampling on the running clock. A timer-source select keeps the timer clock alive when the timer runs from the reference oscillator.

There are seven wake sources: two timers, one port, and four individual port pins. Each source has its own enable bit. In asynchronous mode, a wake request is caught by a latch that needs no clock. The latch re-enables the clocks at once. The request then passes through a synchronizer before the state machine leaves sleep. The block emits a one-cycle wake pulse on its way back to running. With clock-stop set and asynchronous wake clear, only reset brings the block out of sleep.

Top module: `slpwk_ctrl`

## Requirements
- R1: After reset the block is running: `sleeping_o`=0, `wake_o`=0, `cpu_clk_en_o`=1, and `main_clk_en_o` equals `ref_osc_en_i`.
- R2: `idle_req_i` high while running makes `sleeping_o` go high after the next clock edge. `sleeping_o` is high only in the sleep state.
- R3: Outside sleep, and in sleep with `idle_stop_i`=0, `main_clk_en_o` equals `ref_osc_en_i`.
- R4: In sleep with `idle_stop_i`=1 and no captured wake request, `main_clk_en_o` and `cpu_clk_en_o` are 0. `tmr_clk_en_o` is also 0 unless R5 applies.
- R5: In sleep, `tmr_clk_en_o` stays 1 when `tmr_ref_sel_i`=1, whatever `idle_stop_i` is. With `idle_stop_i`=0 it is also 1.
- R6: With `async_wake_i`=1, an enabled interrupt raised in sleep sets `main_clk_en_o` (if `ref_osc_en_i`=1) and `tmr_clk_en_o` with no clock edge. `wake_o` then rises after the third clock edge. This holds with `idle_stop_i` set or clear.
- R7: With `async_wake_i`=0 and `idle_stop_i`=0, an enabled interrupt is sampled on the clock, and `wake_o` rises after the first clock edge.
- R8: With `idle_stop_i`=1 and `async_wake_i`=0, no interrupt ends sleep. The block returns to running only through reset.
- R9: `irq_i` bit 0 is timer 1, bit 1 is timer 2, bit 2 is the port, and bits 3 to 6 are pins 2 to 5. A source whose `irq_en_i` bit is 0 never ends sleep, in either wake mode.
- R10: `wake_o` lasts exactly one cycle and is followed by the running state. `cpu_clk_en_o` is 1 while running and 0 in sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| idle_req_i | input | 1 | CPU idle request |
| idle_stop_i | input | 1 | Gate main and timer clocks in sleep |
| async_wake_i | input | 1 | Select clockless wake capture |
| tmr_ref_sel_i | input | 1 | Timer runs from reference oscillator |
| ref_osc_en_i | input | 1 | Reference oscillator enabled |
| irq_i | input | 7 | Interrupt requests, one per source |
| irq_en_i | input | 7 | Per-source wake enable |
| main_clk_en_o | output | 1 | Main clock enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| tmr_clk_en_o | output | 1 | Timer clock enable |
| sleeping_o | output | 1 | High in sleep state |
| wake_o | output | 1 | One-cycle wake pulse |

## Verification
The bench builds the block with its defaults: seven sources and a two-stage synchronizer. That configuration is small enough to sweep every combination of clock-stop, wake mode and timer select. The sweep crosses each of the seven sources, both enabled and disabled. For each case the bench derives the expected wake latency: three edges for the latch path, one edge for the sampled path, none when masked or locked. It also derives the expected enables during sleep. A further case with the reference oscillator off covers the dependency of the main clock enable.

// File: rtl/slpwk_pkg.sv
package slpwk_pkg;
  localparam int unsigned NUM_SRC_DEF = 7;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WAKE  = 2'd2
  } slp_state_e;
endpackage

// File: rtl/slpwk_wake_latch.sv
// Clockless capture of a wake request; cleared while not sleeping.
module slpwk_wake_latch (
  input  logic set_i,
  input  logic clr_ni,
  output logic pend_o
);
  logic cap_q;

  always_ff @(posedge set_i or negedge clr_ni) begin
    if (!clr_ni) cap_q <= 1'b0;
    else         cap_q <= 1'b1;
  end

  // level path covers a request already high when the clear releases
  assign pend_o = cap_q | (set_i & clr_ni);
endmodule

// File: rtl/slpwk_sync.sv
module slpwk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned W = (STAGES < 2) ? 2 : STAGES;
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[W-2:0], d_i};
  end

  assign q_o = sh_q[W-1];
endmodule

// File: rtl/slpwk_fsm.sv
module slpwk_fsm
  import slpwk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idle_req_i,
  input  logic       wake_go_i,
  output slp_state_e state_o
);
  slp_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (idle_req_i) state_d = ST_SLEEP;
      ST_SLEEP: if (wake_go_i)  state_d = ST_WAKE;
      ST_WAKE:  state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  AST_IDLE_TO_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && idle_req_i) |=> (state_q == ST_SLEEP)); // R2
  AST_WAKE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAKE) |=> (state_q == ST_RUN)); // R10
  AST_WAKE_FROM_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAKE) |-> $past(state_q == ST_SLEEP)); // R10
endmodule

// File: rtl/slpwk_clk_en.sv
module slpwk_clk_en (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleeping_i,
  input  logic idle_stop_i,
  input  logic tmr_ref_sel_i,
  input  logic ref_osc_en_i,
  input  logic restart_i,
  output logic main_en_o,
  output logic cpu_en_o,
  output logic tmr_en_o
);
  logic keep_run;

  assign keep_run  = !sleeping_i || !idle_stop_i || restart_i;
  assign main_en_o = ref_osc_en_i && keep_run;
  assign cpu_en_o  = !sleeping_i;
  assign tmr_en_o  = keep_run || tmr_ref_sel_i;

  AST_TMR_REF_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleeping_i && tmr_ref_sel_i) |-> tmr_en_o); // R5
  AST_MAIN_NEEDS_OSC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_en_o |-> ref_osc_en_i); // R3
endmodule

// File: rtl/slpwk_ctrl.sv
module slpwk_ctrl
  import slpwk_pkg::*;
#(
  parameter int unsigned NUM_SRC     = NUM_SRC_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               idle_req_i,
  input  logic               idle_stop_i,
  input  logic               async_wake_i,
  input  logic               tmr_ref_sel_i,
  input  logic               ref_osc_en_i,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic [NUM_SRC-1:0] irq_en_i,
  output logic               main_clk_en_o,
  output logic               cpu_clk_en_o,
  output logic               tmr_clk_en_o,
  output logic               sleeping_o,
  output logic               wake_o
);
  slp_state_e state;
  logic       sleeping;
  logic       any_irq;
  logic       async_set;
  logic       cap_clr_n;
  logic       pend;
  logic       pend_sync;
  logic       wake_go;

  assign sleeping  = (state == ST_SLEEP);
  assign any_irq   = |(irq_i & irq_en_i);
  assign async_set = sleeping && async_wake_i && any_irq;
  assign cap_clr_n = rst_ni && sleeping;

  slpwk_wake_latch u_latch (
    .set_i  (async_set),
    .clr_ni (cap_clr_n),
    .pend_o (pend)
  );

  slpwk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (cap_clr_n),
    .d_i    (pend),
    .q_o    (pend_sync)
  );

  // async mode waits for the synchronized capture; sync mode needs a running clock
  assign wake_go = async_wake_i ? pend_sync : (!idle_stop_i && any_irq);

  slpwk_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idle_req_i (idle_req_i),
    .wake_go_i  (wake_go),
    .state_o    (state)
  );

  slpwk_clk_en u_clk_en (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sleeping_i    (sleeping),
    .idle_stop_i   (idle_stop_i),
    .tmr_ref_sel_i (tmr_ref_sel_i),
    .ref_osc_en_i  (ref_osc_en_i),
    .restart_i     (pend && async_wake_i),
    .main_en_o     (main_clk_en_o),
    .cpu_en_o      (cpu_clk_en_o),
    .tmr_en_o      (tmr_clk_en_o)
  );

  assign sleeping_o = sleeping;
  assign wake_o     = (state == ST_WAKE);

  AST_LOCKED_NO_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleeping && idle_stop_i && !async_wake_i) |=> !wake_o); // R8
  AST_MASKED_NO_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleeping && !async_wake_i && !any_irq) |=> !wake_o); // R9
  AST_CPU_ON_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RUN) |-> cpu_clk_en_o); // R10
  AST_CPU_OFF_IN_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleeping_o |-> !cpu_clk_en_o); // R10
endmodule

// File: tb/slpwk_ctrl_tb.sv
module slpwk_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int NS = 7;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic idle_req = 1'b0, idle_stop = 1'b0, async_wake = 1'b0;
  logic tmr_sel = 1'b0, ref_osc = 1'b1;
  logic [NS-1:0] irq = '0, irq_en = '0;
  logic main_en, cpu_en, tmr_en, sleeping, wake;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  slpwk_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .idle_req_i(idle_req), .idle_stop_i(idle_stop),
    .async_wake_i(async_wake), .tmr_ref_sel_i(tmr_sel), .ref_osc_en_i(ref_osc),
    .irq_i(irq), .irq_en_i(irq_en), .main_clk_en_o(main_en), .cpu_clk_en_o(cpu_en),
    .tmr_clk_en_o(tmr_en), .sleeping_o(sleeping), .wake_o(wake)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic enter_sleep();
    idle_req = 1'b1;
    @(negedge clk) idle_req = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int src = 0; src < NS; src++) begin
        for (int msk = 0; msk < 2; msk++) begin
          bit st, as, ts, masked, exp_wake;
          int got, exp_n;
          st = cfg[0]; as = cfg[1]; ts = cfg[2]; masked = msk[0];
          idle_stop = st; async_wake = as; tmr_sel = ts; ref_osc = 1'b1;
          irq = '0;
          irq_en = masked ? ~(NS'(1) << src) : (NS'(1) << src);
          do_reset();
          check("R1 sleeping", sleeping, 0);
          check("R1 wake", wake, 0);
          check("R1 cpu_en", cpu_en, 1);
          check("R3 main_en run", main_en, 1);
          enter_sleep();
          check("R2 sleeping", sleeping, 1);
          check("R10 cpu_en sleep", cpu_en, 0);
          check(st ? "R4 main_en" : "R3 main_en", main_en, int'(!st));
          check(ts ? "R5 tmr_en" : "R4 tmr_en", tmr_en, int'(!st || ts));
          irq = NS'(1) << src;
          #1;
          if (as && !masked) begin
            check("R6 main_en async", main_en, 1);
            check("R6 tmr_en async", tmr_en, 1);
          end else begin
            check("R9 main_en masked/idle", main_en, int'(!st));
          end
          exp_wake = !masked && (as || !st);
          exp_n = as ? 3 : 1;
          got = 0;
          for (int n = 1; n <= 6; n++) begin
            @(negedge clk);
            if (got == 0 && wake) got = n;
            if (got != 0) break;
          end
          if (exp_wake) begin
            check(as ? "R6 wake latency" : "R7 wake latency", got, exp_n);
            @(negedge clk);
            check("R10 wake one cycle", wake, 0);
            check("R10 back to run", sleeping, 0);
            check("R10 cpu_en run", cpu_en, 1);
            irq = '0;
          end else begin
            check(masked ? "R9 no wake" : "R8 no wake", got, 0);
            check(masked ? "R9 still asleep" : "R8 still asleep", sleeping, 1);
            irq = '0;
            do_reset();
            check("R8 reset exits", sleeping, 0);
          end
        end
      end
    end
    // reference oscillator off: main enable follows it
    idle_stop = 0; async_wake = 0; tmr_sel = 0; irq = '0; irq_en = '1; ref_osc = 1'b0;
    do_reset();
    check("R1 main_en osc off", main_en, 0);
    enter_sleep();
    check("R3 main_en sleep osc off", main_en, 0);
    ref_osc = 1'b1; #1;
    check("R3 main_en sleep osc on", main_en, 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule